// File: doc/BRIEF.md
# Tile Memory Address Generator

This block produces the byte addresses that an order-preserving matrix tile load or store needs, one per active element. The tile sits in memory as a series of equal-length runs of contiguous elements. Each run holds λ × LMUL elements, and the start of each run lies a programmable leading dimension (LD, counted in elements) after the start of the previous one. The element order on the register side is the same for row-major and column-major matrices. Only LD changes how memory is read, so one address walk covers both layouts.

A one-cycle start pulse captures every operand: the base address, the leading-dimension operand, the element-width code, the length-multiplier code, the 3-bit lambda field, the start index, the vector length and the per-element mask. The block then walks the element indices in ascending order, at one index per cycle. For each index in the body whose mask bit is set, it offers the address, the index and a last flag on a valid/ready handshake. It computes each address from the previous one by adding a step, so there is no multiply per element. A leading-dimension operand of zero selects the natural run length, which makes the tile fully contiguous. When the final access is accepted, busy falls and done pulses. If no index is active, done pulses without any address being offered.

Top module: `tile_addr_gen`

## Requirements
- R1: After synchronous reset, busy_o, valid_o and done_o are all low.
- R2: A start_i pulse while idle captures all operands, and busy_o is high in the following cycle. A start_i pulse while busy is ignored, and the walk in progress continues with its original operands.
- R3: The block offers exactly the indices i with vstart ≤ i < VL and mask bit i equal to 1, in ascending order, one per accepted handshake. Indices outside that set are never offered.
- R4: The address for index i is base + B × ((i >> s) × LD + (i & (2^s − 1))), computed modulo 2^64. B = 2^sew_i bytes (sew_i codes 0..3 give 1, 2, 4, 8 bytes). s = log2(λ) + lmul_i, where lmul_i codes 0..3 give LMUL 1, 2, 4, 8. lam_i values 0..3 give λ = 1, 2, 4, 8, and lam_i values 4..7 give λ = 8.
- R5: When ld_i is zero, LD is taken as 2^s (the run length), so active addresses with consecutive indices are B bytes apart.
- R6: last_o is high on the offered element with the highest active index and low on every other offered element.
- R7: While valid_o is high and ready_i is low, valid_o stays high and addr_o, idx_o and last_o hold their values into the next cycle.
- R8: On the clock edge that accepts the last active element, busy_o falls and done_o rises for exactly one cycle. If no index is active, busy_o is high for one cycle, then done_o pulses once, and valid_o never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures operands when idle |
| base_i | input | 64 | Base byte address |
| ld_i | input | 64 | Leading dimension in elements; 0 selects the run length |
| sew_i | input | 2 | Element width code (bytes = 2^code) |
| lmul_i | input | 2 | Length multiplier code (LMUL = 2^code) |
| lam_i | input | 3 | Lambda field (0..3 give 1, 2, 4, 8; 4..7 give 8) |
| vstart_i | input | 7 | First element index of the body |
| vl_i | input | 7 | Vector length (end of body, exclusive) |
| mask_i | input | 64 | Per-element enable, bit i for index i |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| valid_o | output | 1 | An address is offered |
| ready_i | input | 1 | Consumer accepts the offered address |
| addr_o | output | 64 | Byte address of the offered element |
| idx_o | output | 7 | Element index of the offered element |
| last_o | output | 1 | Offered element is the final active one |

## Verification
The assertions assume that vl_i never exceeds the mask width of 64. They also assume that start_i is raised only while the consumer keeps to the handshake rule, so ready_i alone decides acceptance and valid_o is never withdrawn by the consumer. The stimulus keeps every VL within 64 and drives start_i as a single-cycle pulse. Ready is always high in some runs, random in others and alternating in others, so that stalls fall both inside runs and at run boundaries. The lambda field is also driven with the values 4 to 7, which the block accepts and maps to λ = 8.

// File: rtl/tagen_pkg.sv
package tagen_pkg;

    localparam int ADDR_W_DEF = 64;
    localparam int MAX_VL_DEF = 64;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_e;

    // Run geometry kept after start
    typedef struct packed {
        logic [1:0] sew_log2;
        logic [2:0] seg_log2;
    } geom_t;

    // Lambda field to log2(lambda); codes above 3 saturate at 8
    function automatic logic [2:0] lam_to_log2(input logic [2:0] field);
        return field[2] ? 3'd3 : {1'b0, field[1:0]};
    endfunction

    // log2 of run length = log2(lambda) + log2(LMUL)
    function automatic logic [2:0] seg_len_log2(input logic [2:0] lam_field,
                                                input logic [1:0] lmul_code);
        return lam_to_log2(lam_field) + {1'b0, lmul_code};
    endfunction

endpackage

// File: rtl/tagen_geom.sv
module tagen_geom
    import tagen_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] ld_i,
    input  logic [1:0]        sew_i,
    input  logic [1:0]        lmul_i,
    input  logic [2:0]        lam_i,
    input  logic [IDX_W-1:0]  vstart_i,
    output geom_t             geom_o,
    output logic [ADDR_W-1:0] first_addr_o,
    output logic [ADDR_W-1:0] seg_jump_o,
    output logic [IDX_W-1:0]  seg_mask_o
);
    logic [2:0]        s_log2;
    logic [ADDR_W-1:0] run_len;
    logic [ADDR_W-1:0] ld_eff;
    logic [ADDR_W-1:0] vs_wide;
    logic [ADDR_W-1:0] seg_no;
    logic [ADDR_W-1:0] seg_off;
    logic [ADDR_W-1:0] elem_off;
    logic [ADDR_W-1:0] len_mask;

    always_comb begin
        s_log2   = seg_len_log2(lam_i, lmul_i);
        run_len  = ADDR_W'(1) << s_log2;
        len_mask = run_len - ADDR_W'(1);
        // zero operand selects the natural (contiguous) dimension
        ld_eff   = (ld_i == '0) ? run_len : ld_i;
        vs_wide  = ADDR_W'(vstart_i);
        seg_no   = vs_wide >> s_log2;
        seg_off  = vs_wide & len_mask;
        // single multiply at start only; per-element steps are additions
        elem_off = seg_no * ld_eff + seg_off;
        first_addr_o = base_i + (elem_off << sew_i);
        seg_jump_o   = (ld_eff - run_len + ADDR_W'(1)) << sew_i;
        seg_mask_o   = len_mask[IDX_W-1:0];
        geom_o.sew_log2 = sew_i;
        geom_o.seg_log2 = s_log2;
    end
endmodule

// File: rtl/tagen_window.sv
module tagen_window #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = 7
) (
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IDX_W-1:0]  vl_i,
    output logic              cur_en_o,
    output logic              rem_any_o,
    output logic              last_o
);
    logic [MAX_VL-1:0] from_cur;
    logic [MAX_VL-1:0] after_cur;
    logic [MAX_VL-1:0] at_cur;

    for (genvar j = 0; j < MAX_VL; j++) begin : g_lane
        logic below_vl;
        assign below_vl     = IDX_W'(j) < vl_i;
        assign from_cur[j]  = mask_i[j] && below_vl && (IDX_W'(j) >= idx_i);
        assign after_cur[j] = mask_i[j] && below_vl && (IDX_W'(j) > idx_i);
        assign at_cur[j]    = from_cur[j] && (IDX_W'(j) == idx_i);
    end

    assign cur_en_o  = |at_cur;
    assign rem_any_o = |from_cur;
    assign last_o    = ~|after_cur;
endmodule

// File: rtl/tagen_seq.sv
module tagen_seq
    import tagen_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int MAX_VL = MAX_VL_DEF,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  geom_t             geom_i,
    input  logic [ADDR_W-1:0] first_addr_i,
    input  logic [ADDR_W-1:0] seg_jump_i,
    input  logic [IDX_W-1:0]  seg_mask_i,
    input  logic [IDX_W-1:0]  vstart_i,
    input  logic [IDX_W-1:0]  vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic              ready_i,
    input  logic              win_cur_i,
    input  logic              win_rem_i,
    input  logic              win_last_i,
    output logic              run_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  vl_o,
    output logic [MAX_VL-1:0] mask_o,
    output logic              done_o
);
    walk_state_e       state_q;
    geom_t             geom_q;
    logic [ADDR_W-1:0] jump_q;
    logic [IDX_W-1:0]  seg_mask_q;
    logic [IDX_W-1:0]  vstart_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  vl_q;
    logic [MAX_VL-1:0] mask_q;
    logic              done_q;

    logic              running;
    logic              fire;
    logic              finish;
    logic              step;
    logic [IDX_W-1:0]  idx_nx;
    logic              crosses;
    logic [ADDR_W-1:0] elem_bytes;

    always_comb begin
        running    = (state_q == ST_RUN);
        fire       = running && win_cur_i && ready_i;
        finish     = running && (!win_rem_i || (fire && win_last_i));
        step       = running && !finish && (fire || !win_cur_i);
        idx_nx     = idx_q + IDX_W'(1);
        crosses    = (idx_nx & seg_mask_q) == '0;
        elem_bytes = ADDR_W'(1) << geom_q.sew_log2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            geom_q     <= '0;
            jump_q     <= '0;
            seg_mask_q <= '0;
            vstart_q   <= '0;
            idx_q      <= '0;
            addr_q     <= '0;
            vl_q       <= '0;
            mask_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (!running) begin
                if (start_i) begin
                    state_q    <= ST_RUN;
                    geom_q     <= geom_i;
                    jump_q     <= seg_jump_i;
                    seg_mask_q <= seg_mask_i;
                    vstart_q   <= vstart_i;
                    idx_q      <= vstart_i;
                    addr_q     <= first_addr_i;
                    vl_q       <= vl_i;
                    mask_q     <= mask_i;
                end
            end else if (finish) begin
                state_q <= ST_IDLE;
            end else if (step) begin
                idx_q  <= idx_nx;
                addr_q <= addr_q + (crosses ? jump_q : elem_bytes);
            end
        end
    end

    assign run_o  = running;
    assign idx_o  = idx_q;
    assign addr_o = addr_q;
    assign vl_o   = vl_q;
    assign mask_o = mask_q;
    assign done_o = done_q;

    // R2: an idle start begins the walk at the start index
    p_start_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !running && start_i |=> running && idx_q == $past(vstart_i));

    // R2: a start while busy does not rewind the index
    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        running && start_i && !finish |=> idx_q >= $past(idx_q));

    // R3: index only moves forward by one while walking
    p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
        running && !finish |=> idx_q == $past(idx_q) || idx_q == $past(idx_q) + IDX_W'(1));

    // R3: the index never leaves the body while a walk is active
    p_idx_window_r3: assert property (@(posedge clk) disable iff (rst)
        running && win_cur_i |-> idx_q >= vstart_q && idx_q < vl_q);

    // R8: done is a single-cycle pulse with the block idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !running ##1 !done_q);
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tagen_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int MAX_VL = MAX_VL_DEF,
    localparam int IDX_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] ld_i,
    input  logic [1:0]        sew_i,
    input  logic [1:0]        lmul_i,
    input  logic [2:0]        lam_i,
    input  logic [IDX_W-1:0]  vstart_i,
    input  logic [IDX_W-1:0]  vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o
);
    geom_t             geom;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] seg_jump;
    logic [IDX_W-1:0]  seg_mask;
    logic              run;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  vl_q;
    logic [MAX_VL-1:0] mask_q;
    logic              win_cur;
    logic              win_rem;
    logic              win_last;
    logic              done;

    tagen_geom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_geom (
        .base_i      (base_i),
        .ld_i        (ld_i),
        .sew_i       (sew_i),
        .lmul_i      (lmul_i),
        .lam_i       (lam_i),
        .vstart_i    (vstart_i),
        .geom_o      (geom),
        .first_addr_o(first_addr),
        .seg_jump_o  (seg_jump),
        .seg_mask_o  (seg_mask)
    );

    tagen_seq #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .geom_i      (geom),
        .first_addr_i(first_addr),
        .seg_jump_i  (seg_jump),
        .seg_mask_i  (seg_mask),
        .vstart_i    (vstart_i),
        .vl_i        (vl_i),
        .mask_i      (mask_i),
        .ready_i     (ready_i),
        .win_cur_i   (win_cur),
        .win_rem_i   (win_rem),
        .win_last_i  (win_last),
        .run_o       (run),
        .idx_o       (idx_q),
        .addr_o      (addr_q),
        .vl_o        (vl_q),
        .mask_o      (mask_q),
        .done_o      (done)
    );

    tagen_window #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_window (
        .mask_i   (mask_q),
        .idx_i    (idx_q),
        .vl_i     (vl_q),
        .cur_en_o (win_cur),
        .rem_any_o(win_rem),
        .last_o   (win_last)
    );

    assign busy_o  = run;
    assign done_o  = done;
    assign valid_o = run && win_cur;
    assign addr_o  = addr_q;
    assign idx_o   = idx_q;
    assign last_o  = win_last;

    // R1: nothing is offered or reported right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !busy_o && !valid_o && !done_o);

    // R7: a stalled offer is held unchanged
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(idx_o) && $stable(last_o));

    // R8: acceptance of the last element ends the walk next cycle
    p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o && ready_i && last_o |=> !busy_o && done_o);

    // R3: offers only occur while busy
    p_valid_busy_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> busy_o);
endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
    localparam int MAXVL = 64;
    localparam int IW    = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [63:0]     base_i = '0;
    logic [63:0]     ld_i = '0;
    logic [1:0]      sew_i = '0;
    logic [1:0]      lmul_i = '0;
    logic [2:0]      lam_i = '0;
    logic [IW-1:0]   vstart_i = '0;
    logic [IW-1:0]   vl_i = '0;
    logic [MAXVL-1:0] mask_i = '0;
    logic            ready_i = 1'b1;
    logic            busy_o, done_o, valid_o, last_o;
    logic [63:0]     addr_o;
    logic [IW-1:0]   idx_o;

    always #10 clk = ~clk;

    tile_addr_gen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .ld_i(ld_i),
        .sew_i(sew_i), .lmul_i(lmul_i), .lam_i(lam_i), .vstart_i(vstart_i),
        .vl_i(vl_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
        .valid_o(valid_o), .ready_i(ready_i), .addr_o(addr_o), .idx_o(idx_o),
        .last_o(last_o)
    );

    typedef struct {
        logic [63:0] a;
        int          i;
        bit          l;
    } exp_t;

    exp_t        expq[$];
    int          checks = 0;
    int          fails = 0;
    int          ready_mode = 0;
    int          done_seen = 0;
    bit          sampling = 0;
    bit          prev_hold = 0;
    bit          want_done = 0;
    logic [63:0] hold_a;
    logic [IW-1:0] hold_i;
    bit          hold_l;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: full formula with multiply, independent of the walk
    task automatic build(input logic [63:0] base, input logic [63:0] ld, input int sew,
                         input int lmul, input int lam, input int vs, input int vl,
                         input logic [MAXVL-1:0] m);
        int lam_v;
        longint unsigned ls, ldv, bytes;
        int last_i;
        lam_v = (lam >= 4) ? 8 : (1 << lam);
        ls    = longint'(lam_v) * (longint'(1) << lmul);
        ldv   = (ld == 0) ? ls : ld;
        bytes = longint'(1) << sew;
        expq.delete();
        last_i = -1;
        for (int i = vs; i < vl; i++) if (m[i]) last_i = i;
        for (int i = vs; i < vl; i++) begin
            if (m[i]) begin
                exp_t e;
                longint unsigned ui;
                ui  = longint'(i);
                e.a = base + bytes * ((ui / ls) * ldv + (ui % ls));
                e.i = i;
                e.l = (i == last_i);
                expq.push_back(e);
            end
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (sampling) begin
            if (prev_hold)
                chk(valid_o && addr_o == hold_a && idx_o == hold_i && last_o == hold_l,
                    "R7", "stalled offer changed", addr_o, hold_a);
            if (want_done)
                chk(done_o && !busy_o, "R8", "done/busy after last accept",
                    {62'd0, done_o, busy_o}, 64'd2);
            want_done = 0;
            if (done_o) done_seen++;
            case (ready_mode)
                0: ready_i = 1'b1;
                1: ready_i = 1'($urandom % 2);
                default: ready_i = ~ready_i;
            endcase
            prev_hold = 0;
            if (valid_o) begin
                if (expq.size() == 0) begin
                    chk(0, "R3", "unexpected offer idx", 64'(idx_o), 64'hffff);
                end else begin
                    exp_t e;
                    e = expq[0];
                    chk(int'(idx_o) == e.i, "R3", "index", 64'(idx_o), 64'(e.i));
                    chk(addr_o == e.a, "R4", "address", addr_o, e.a);
                    chk(last_o == e.l, "R6", "last flag", 64'(last_o), 64'(e.l));
                    if (ready_i) begin
                        void'(expq.pop_front());
                        if (e.l) want_done = 1;
                    end else begin
                        prev_hold = 1;
                        hold_a = addr_o; hold_i = idx_o; hold_l = last_o;
                    end
                end
            end
        end
    end

    task automatic run_op(input string tag, input logic [63:0] base, input logic [63:0] ld,
                          input int sew, input int lmul, input int lam, input int vs,
                          input int vl, input logic [MAXVL-1:0] m, input int rmode,
                          input bit poke);
        bit got;
        build(base, ld, sew, lmul, lam, vs, vl, m);
        ready_mode = rmode;
        done_seen = 0;
        @(negedge clk);
        base_i = base; ld_i = ld; sew_i = 2'(sew); lmul_i = 2'(lmul); lam_i = 3'(lam);
        vstart_i = IW'(vs); vl_i = IW'(vl); mask_i = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2", {tag, " busy after start"}, 64'(busy_o), 64'd1);
        if (poke) begin
            // R2: disturb operands and restart while busy
            base_i = ~base; ld_i = ld + 64'd3; vstart_i = '0; mask_i = ~m;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        got = 0;
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            if (done_seen > 0) begin got = 1; break; end
        end
        chk(got, "R8", {tag, " done seen"}, 64'(got), 64'd1);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R3", {tag, " all active indices offered"},
            64'(expq.size()), 64'd0);
        chk(done_seen == 1, "R8", {tag, " single done pulse"}, 64'(done_seen), 64'd1);
        chk(!busy_o && !valid_o, "R8", {tag, " idle after done"},
            {62'd0, busy_o, valid_o}, 64'd0);
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [MAXVL-1:0] all1;
        all1 = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !valid_o && !done_o, "R1", "reset state",
            {61'd0, busy_o, valid_o, done_o}, 64'd0);
        sampling = 1;

        // R5: zero LD gives a contiguous tile
        run_op("R5 natural", 64'h1000, 64'd0, 2, 0, 1, 0, 16, all1, 0, 0);
        // R4: strided runs, random mask and stalls
        run_op("R4 strided", 64'h8000_0000, 64'd100, 3, 1, 1, 0, 20,
               {$urandom, $urandom}, 1, 0);
        // R4: start index mid-run, alternating ready
        run_op("R4 mid start", 64'h40, 64'd37, 0, 2, 0, 5, 30, all1, 2, 0);
        // R4: lambda field 5 saturates to 8, run length 64
        run_op("R4 lam clamp", 64'h2_0000, 64'd70, 1, 3, 5, 3, 64,
               {$urandom, $urandom}, 1, 0);
        // R4: address wraps modulo 2^64
        run_op("R4 wrap", 64'hFFFF_FFFF_FFFF_FFF0, 64'd1000, 3, 0, 1, 0, 10, all1, 0, 0);
        // R8: all masked off
        run_op("R8 empty mask", 64'h100, 64'd4, 0, 0, 0, 0, 8, '0, 0, 0);
        // R3/R8: empty body
        run_op("R3 empty body", 64'h100, 64'd4, 0, 0, 0, 10, 10, all1, 0, 0);
        // R2: start while busy is ignored
        run_op("R2 restart", 64'h5000, 64'd9, 2, 1, 0, 1, 24, all1, 1, 1);
        // R6: single active element at the end of the body
        run_op("R6 single", 64'h7000, 64'd5, 1, 1, 1, 0, 12, 64'h800, 1, 0);
        // R7: long stalls on a contiguous run
        run_op("R7 stall", 64'h9000, 64'd0, 3, 2, 2, 2, 40, all1, 1, 0);
        for (int n = 0; n < 12; n++) begin
            int vs, vl;
            vl = 1 + int'($urandom % 64);
            vs = int'($urandom % 65) % (vl + 1);
            run_op("R3 random", {$urandom, $urandom}, 64'($urandom % 200),
                   int'($urandom % 4), int'($urandom % 4), int'($urandom % 8),
                   vs, vl, {$urandom, $urandom}, int'($urandom % 3), 0);
        end

        sampling = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule